// File: doc/BRIEF.md
# UART Receive Interrupt Prioritizer

This block decides whether the receive side of a FIFO-equipped UART needs service, and tells software why. It looks at the current receive FIFO fill count, a trigger threshold chosen through a 2-bit select field, the error flags of the character sitting at the head of the FIFO, and the enable bits held in the FIFO-control and interrupt-enable registers. From these it produces a registered interrupt request, an 8-bit identification code and a data-ready status bit.

Two receive conditions exist. The data-available condition follows the fill level: it is present exactly while the count is at or above the selected threshold. The line-status condition is present while the head character carries a parity, framing or break flag, and it takes precedence in the identification code. The FIFO storage, the deserializer and the register decode sit outside; their status is supplied on the input pins and a push pulse marks each character entering the FIFO.

Top module: `uart_rx_irq_prio`

## Requirements
- R1: While reset is asserted and at the first edge after it, `irq` is 0, `iid` is 0xC1 and `data_ready` is 0.
- R2: If `fifo_en` or `rx_irq_en` is 0, the next clock leaves `irq` at 0 and `iid` at 0xC1, whatever the count and error flags are.
- R3: With both enables at 1 and no line-status condition, a count at or above the selected threshold gives `irq` = 1 and `iid` = 0xC4 one clock later.
- R4: When the count is below the selected threshold and no line-status condition is present, the next clock gives `irq` = 0 and `iid` = 0xC1.
- R5: `trig_sel` picks the threshold: 0 selects 1 entry, 1 selects 4, 2 selects 8, 3 selects 14.
- R6: With both enables and `ls_irq_en` at 1, a count above zero and any of `head_parity_err`, `head_frame_err`, `head_break` at 1, the next clock gives `irq` = 1 and `iid` = 0xC6.
- R7: When line-status and data-available are both pending, `iid` reports 0xC6 and `irq` is 1.
- R8: Head error flags have no effect when the count is zero or `ls_irq_en` is 0.
- R9: `data_ready` becomes 1 on the clock after `rx_push` is 1, holds while the count is non-zero, and clears on the clock after the count is zero with `rx_push` at 0; a push wins over an empty count in the same cycle.
- R10: `iid` bit 0 is 1 exactly when `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable from the FIFO-control register |
| rx_irq_en | input | 1 | Receive interrupt enable |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| trig_sel | input | 2 | Threshold select: 1, 4, 8 or 14 entries |
| fifo_count | input | 5 | Current receive FIFO fill count |
| head_parity_err | input | 1 | Parity error on the head character |
| head_frame_err | input | 1 | Framing error on the head character |
| head_break | input | 1 | Break indication on the head character |
| rx_push | input | 1 | Pulse: a character enters the FIFO this cycle |
| irq | output | 1 | Registered interrupt request |
| iid | output | 8 | Registered identification code |
| data_ready | output | 1 | Registered data-ready status |

## Verification
Line-status and data-available can both be pending in one cycle; the bench provokes this by presenting a head error while the count also meets the threshold, and judges that the code is 0xC6 and not 0xC4, then drops only the line-status enable and expects 0xC4. The data-ready register can likewise see a push and an empty count together; that case is driven with a push while the count is still zero, and the bit must read 1 on the next clock.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;

  localparam logic [7:0] IID_NONE = 8'hC1;
  localparam logic [7:0] IID_DATA = 8'hC4;
  localparam logic [7:0] IID_LINE = 8'hC6;

  localparam int unsigned NUM_TRIG = 4;

  // Threshold in entries for each value of the select field.
  function automatic int unsigned trig_level(input int unsigned sel);
    case (sel)
      0:       return 1;
      1:       return 4;
      2:       return 8;
      default: return 14;
    endcase
  endfunction

  // Identification code chosen from the pending conditions, line status first.
  function automatic logic [7:0] pick_iid(input logic line_p, input logic data_p);
    if (line_p)      return IID_LINE;
    else if (data_p) return IID_DATA;
    else             return IID_NONE;
  endfunction

endpackage

// File: rtl/rx_trig_cmp.sv
module rx_trig_cmp
  import uart_rx_irq_pkg::*;
#(
  parameter int unsigned COUNT_W = 5
) (
  input  logic [COUNT_W-1:0] count,
  input  logic [1:0]         sel,
  output logic               at_level
);

  logic [NUM_TRIG-1:0] hit;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_lvl
    assign hit[g] = 32'(count) >= trig_level(g);
  end

  assign at_level = hit[sel];

endmodule

// File: rtl/rx_head_err.sv
module rx_head_err #(
  parameter int unsigned NUM_ERR = 3
) (
  input  logic [NUM_ERR-1:0] err_flags,
  input  logic               nonempty,
  output logic               head_bad
);

  assign head_bad = nonempty && (|err_flags);

endmodule

// File: rtl/rx_irq_arb.sv
module rx_irq_arb
  import uart_rx_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_pend,
  input  logic       data_pend,
  output logic       irq_q,
  output logic [7:0] iid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      iid_q <= IID_NONE;
    end else begin
      irq_q <= line_pend | data_pend;
      iid_q <= pick_iid(line_pend, data_pend);
    end
  end

  // R7: line status outranks data available
  a_r7_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pend && data_pend) |=> (iid_q == IID_LINE && irq_q));

  // R10: code bit 0 mirrors absence of a request
  a_r10_iid_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    iid_q[0] == !irq_q);

  // R4: nothing pending gives the idle code
  a_r4_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_pend && !data_pend) |=> (iid_q == IID_NONE));

endmodule

// File: rtl/rx_dready.sv
module rx_dready (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic empty,
  output logic ready_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ready_q <= 1'b0;
    else if (push)  ready_q <= 1'b1;
    else if (empty) ready_q <= 1'b0;
  end

  // R9: a push always sets the bit
  a_r9_push_sets: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ready_q);

  // R9: empty without push clears the bit
  a_r9_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> !ready_q);

  // R9: non-empty without push holds the bit
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !push) |=> $stable(ready_q));

endmodule

// File: rtl/uart_rx_irq_prio.sv
module uart_rx_irq_prio
  import uart_rx_irq_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned NUM_ERR = 3,
  localparam int unsigned COUNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               rx_irq_en,
  input  logic               ls_irq_en,
  input  logic [1:0]         trig_sel,
  input  logic [COUNT_W-1:0] fifo_count,
  input  logic               head_parity_err,
  input  logic               head_frame_err,
  input  logic               head_break,
  input  logic               rx_push,
  output logic               irq,
  output logic [7:0]         iid,
  output logic               data_ready
);

  // Named internal events for the checks below.
  logic rx_enabled;
  logic fifo_empty;
  logic at_level;
  logic head_bad;
  logic line_pend;
  logic data_pend;

  assign rx_enabled = fifo_en && rx_irq_en;
  assign fifo_empty = (fifo_count == '0);

  rx_trig_cmp #(.COUNT_W(COUNT_W)) u_trig (
    .count    (fifo_count),
    .sel      (trig_sel),
    .at_level (at_level)
  );

  rx_head_err #(.NUM_ERR(NUM_ERR)) u_herr (
    .err_flags ({head_break, head_frame_err, head_parity_err}),
    .nonempty  (!fifo_empty),
    .head_bad  (head_bad)
  );

  assign line_pend = rx_enabled && ls_irq_en && head_bad;
  assign data_pend = rx_enabled && at_level;

  rx_irq_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_pend (line_pend),
    .data_pend (data_pend),
    .irq_q     (irq),
    .iid_q     (iid)
  );

  rx_dready u_dr (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (rx_push),
    .empty   (fifo_empty),
    .ready_q (data_ready)
  );

  // R2: enables off means no request
  a_r2_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_en && rx_irq_en) |=> (!irq && iid == IID_NONE));

  // R3/R5: count at the selected threshold raises a request
  a_r3_level_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_irq_en && 32'(fifo_count) >= trig_level(32'(trig_sel))) |=> irq);

  // R8: an empty FIFO never yields the line-status code
  a_r8_empty_no_line: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |=> (iid != IID_LINE));

  // R6: head error with everything enabled yields the line-status code
  a_r6_line_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_irq_en && ls_irq_en && fifo_count != '0 &&
     (head_parity_err || head_frame_err || head_break)) |=> (iid == IID_LINE));

endmodule

// File: tb/uart_rx_irq_prio_tb.sv
module uart_rx_irq_prio_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, rx_irq_en = 1'b0, ls_irq_en = 1'b0;
  logic [1:0] trig_sel = '0;
  logic [4:0] fifo_count = '0;
  logic       pe = 1'b0, fe = 1'b0, bi = 1'b0, push = 1'b0;
  logic       irq;
  logic [7:0] iid;
  logic       data_ready;

  int n_checks = 0;
  int n_fail = 0;
  logic dr_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_irq_prio u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
    .ls_irq_en(ls_irq_en), .trig_sel(trig_sel), .fifo_count(fifo_count),
    .head_parity_err(pe), .head_frame_err(fe), .head_break(bi),
    .rx_push(push), .irq(irq), .iid(iid), .data_ready(data_ready)
  );

  // Layout: [26:23] req, [22] fifo_en, [21] rx_en, [20] ls_en, [19:18] sel,
  // [17:13] count, [12] pe, [11] fe, [10] brk, [9] push, [8] irq, [7:0] iid
  localparam logic [26:0] VEC [NV] = '{
    {4'd4, 3'b111, 2'd0, 5'd0,  3'b000, 1'b0, 1'b0, 8'hC1}, // R4 empty
    {4'd9, 3'b111, 2'd0, 5'd0,  3'b000, 1'b1, 1'b0, 8'hC1}, // R9 push wins over empty
    {4'd3, 3'b111, 2'd0, 5'd1,  3'b000, 1'b0, 1'b1, 8'hC4}, // R3 threshold 1
    {4'd5, 3'b111, 2'd1, 5'd3,  3'b000, 1'b0, 1'b0, 8'hC1}, // R5 below 4
    {4'd5, 3'b111, 2'd1, 5'd4,  3'b000, 1'b0, 1'b1, 8'hC4}, // R5 at 4
    {4'd5, 3'b111, 2'd2, 5'd7,  3'b000, 1'b0, 1'b0, 8'hC1}, // R5 below 8
    {4'd5, 3'b111, 2'd2, 5'd8,  3'b000, 1'b0, 1'b1, 8'hC4}, // R5 at 8
    {4'd5, 3'b111, 2'd3, 5'd13, 3'b000, 1'b0, 1'b0, 8'hC1}, // R5 below 14
    {4'd5, 3'b111, 2'd3, 5'd14, 3'b000, 1'b0, 1'b1, 8'hC4}, // R5 at 14
    {4'd3, 3'b111, 2'd3, 5'd16, 3'b000, 1'b0, 1'b1, 8'hC4}, // R3 full
    {4'd6, 3'b111, 2'd3, 5'd2,  3'b100, 1'b0, 1'b1, 8'hC6}, // R6 parity
    {4'd6, 3'b111, 2'd3, 5'd2,  3'b010, 1'b0, 1'b1, 8'hC6}, // R6 framing
    {4'd6, 3'b111, 2'd3, 5'd2,  3'b001, 1'b0, 1'b1, 8'hC6}, // R6 break
    {4'd7, 3'b111, 2'd0, 5'd5,  3'b100, 1'b0, 1'b1, 8'hC6}, // R7 both pending
    {4'd8, 3'b110, 2'd0, 5'd5,  3'b100, 1'b0, 1'b1, 8'hC4}, // R8 ls disabled
    {4'd8, 3'b111, 2'd3, 5'd0,  3'b010, 1'b0, 1'b0, 8'hC1}, // R8 empty with error
    {4'd2, 3'b011, 2'd0, 5'd5,  3'b100, 1'b0, 1'b0, 8'hC1}, // R2 fifo off
    {4'd2, 3'b101, 2'd0, 5'd5,  3'b100, 1'b0, 1'b0, 8'hC1}, // R2 rx irq off
    {4'd9, 3'b111, 2'd1, 5'd3,  3'b000, 1'b1, 1'b0, 8'hC1}, // R9 push sets
    {4'd4, 3'b111, 2'd1, 5'd4,  3'b000, 1'b0, 1'b1, 8'hC4}, // R4 at level
    {4'd4, 3'b111, 2'd1, 5'd3,  3'b000, 1'b0, 1'b0, 8'hC1}, // R4 drops below
    {4'd10, 3'b111, 2'd2, 5'd9, 3'b000, 1'b0, 1'b1, 8'hC4}  // R10 bit0 low
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    string tag;
    // R1: reset values
    #(CLK_PERIOD * 2);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 iid", iid, 8'hC1);
    check("R1 dready", {7'd0, data_ready}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {fifo_en, rx_irq_en, ls_irq_en} = VEC[i][22:20];
      trig_sel   = VEC[i][19:18];
      fifo_count = VEC[i][17:13];
      {pe, fe, bi} = VEC[i][12:10];
      push       = VEC[i][9];
      if (push) dr_exp = 1'b1;
      else if (fifo_count == 0) dr_exp = 1'b0;
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", VEC[i][26:23], i);
      check({tag, " irq"}, {7'd0, irq}, {7'd0, VEC[i][8]});
      check({tag, " iid"}, iid, VEC[i][7:0]);
      check({tag, " R9 dready"}, {7'd0, data_ready}, {7'd0, dr_exp});
      check({tag, " R10 bit0"}, {7'd0, iid[0]}, {7'd0, ~irq});
    end

    // R9: hold while non-empty without push, then clear on empty
    fifo_en = 1'b0; push = 1'b1; fifo_count = 5'd2;
    @(negedge clk);
    push = 1'b0;
    @(negedge clk);
    check("R9 hold", {7'd0, data_ready}, 8'h01);
    fifo_count = 5'd0;
    @(negedge clk);
    check("R9 clear", {7'd0, data_ready}, 8'h00);

    // R1: reset in the middle of activity
    {fifo_en, rx_irq_en, ls_irq_en} = 3'b111;
    fifo_count = 5'd3; pe = 1'b1; push = 1'b1;
    @(negedge clk);
    check("R6 pre-reset", iid, 8'hC6);
    rst_n = 1'b0;
    #1;
    check("R1 mid irq", {7'd0, irq}, 8'h00);
    check("R1 mid iid", iid, 8'hC1);
    check("R1 mid dready", {7'd0, data_ready}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule